// File: doc/BRIEF.md
# Burst Transfer Engine for an AHB-Lite Manager Port

This block turns single commands into bus traffic on a 32-bit AHB-Lite manager port. A command carries a start address, a direction, an access width (byte, halfword or word), a burst choice (one beat, or a four-beat wrapping burst) and, for writes, the data for every beat. The engine presents one address/control phase for each beat. The address phase of the next beat overlaps the data phase of the current one. Both phases stretch for as long as the subordinate holds the ready line low.

While a burst is in flight, the user can hold a pause input high. The engine then shows BUSY cycles between beats instead of the next SEQ beat. Read data is taken off the bus only when a beat completes. It is moved down from the active byte lanes and handed to the user with its beat index. An ERROR response cancels the beats that have not yet been issued, and the failure is reported with the end-of-command pulse. Only one command is in flight at a time. There is one manager, no locking and no arbitration.

Top module: `ahb_burst_mgr`

## Requirements
- R1: While reset is asserted and directly after it, htrans is IDLE (2'b00), cmd_ready is 1, and done and rd_valid are 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. In the next cycle htrans is NONSEQ (2'b10) at cmd_addr. In that same cycle hwrite equals cmd_write, hsize is 3'b000, 3'b001 or 3'b010 for cmd_size 0, 1 or 2 (a cmd_size of 3 is treated as word), and hburst is 3'b000 for a single beat or 3'b010 for a wrapping burst (cmd_wrap=1).
- R3: The transfer type codes are IDLE=00, BUSY=01, NONSEQ=10 and SEQ=11. The first beat of a command is NONSEQ, and beats 1 to 3 of a wrapping burst are SEQ.
- R4: In a wrapping burst, each next address adds the beat size in bytes to the previous one, modulo a block of 4 × beat size. The address bits above that block never change, so byte beats starting at 0x33 visit 0x33, 0x30, 0x31, 0x32.
- R5: The address phase of beat N+1 is shown while beat N is in its data phase. While hready is low, haddr and htrans hold their values, unless an ERROR response is under way.
- R6: During a write data phase, hwdata carries the beat's data replicated across the bus, so that the byte lanes selected by the address's low two bits and the size hold the beat's low-order bytes. hwdata holds steady until hready is sampled high.
- R7: After each read beat that completes with an OKAY response, rd_valid is 1 for one cycle, in the cycle after the completing edge. In that cycle rd_data holds the active lanes moved down to bit 0 and zero-extended, and rd_beat holds the beat's index (0 for the first beat issued).
- R8: usr_pause is sampled on each edge where hready is high and another beat is still to be issued. While it is high, htrans is BUSY and haddr shows the next beat's address. Once it is low, that beat goes out as SEQ at the same address, and the address sequence does not change.
- R9: In the first cycle of an ERROR response (hresp=1, hready=0), the engine drives IDLE in the following cycle. No further beats are issued, no rd_valid is produced for the failed beat, and the command ends with done_err=1.
- R10: done is a one-cycle pulse in the cycle after the last beat completes (or after an ERROR ends the command), with done_err=0 on success. cmd_ready is 1 again in that same cycle.
- R11: A single-beat command issues exactly one NONSEQ and never shows SEQ or BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be accepted |
| cmd_addr | input | ADDR_W | Start address, aligned to the size |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cmd_wrap | input | 1 | 1 = four-beat wrapping burst, 0 = single beat |
| cmd_wdata | input | 128 | Write data, beat k in bits 32k+31:32k |
| usr_pause | input | 1 | Request BUSY cycles between beats |
| rd_valid | output | 1 | Read beat data valid |
| rd_data | output | 32 | Read data, zero-extended |
| rd_beat | output | 2 | Index of the read beat |
| done | output | 1 | Command finished pulse |
| done_err | output | 1 | Command ended by ERROR |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus access size |
| hburst | output | 3 | Bus burst kind |
| hwdata | output | 32 | Bus write data |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Subordinate ready |
| hresp | input | 1 | Subordinate error response |

## Verification
A beat counter that is off by one shows up at once, in the first SEQ address after NONSEQ, as a wrong wrap position or a burst of the wrong length. A stale data-phase register shows up on hwdata or rd_data in the very cycle that beat completes, as the wrong lane contents or a wrong beat index. A pause or error path that misses its edge shows up within one cycle on htrans: a SEQ where BUSY was due, or a transfer left running after the first error cycle. Every failure of this kind appears within a cycle or two of its cause, well before done.

// File: rtl/ahb_mgr_pkg.sv
package ahb_mgr_pkg;

  localparam int BUS_W      = 32;
  localparam int WRAP_BEATS = 4;
  localparam int BEAT_IW    = $clog2(WRAP_BEATS);
  localparam int LO_W       = 8;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_WRAP4  = 3'b010;

  // next wrapping address, low bits only
  function automatic logic [LO_W-1:0] wrap_step(input logic [LO_W-1:0] lo,
                                                input logic [1:0] sz);
    logic [LO_W-1:0] step;
    logic [LO_W-1:0] span;
    step = LO_W'(1) << sz;
    span = (step << BEAT_IW) - LO_W'(1);
    return (lo & ~span) | ((lo + step) & span);
  endfunction

  // replicate narrow write data onto every lane group
  function automatic logic [BUS_W-1:0] lane_spread(input logic [BUS_W-1:0] d,
                                                   input logic [1:0] sz);
    case (sz)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  // pull active lanes down to bit 0
  function automatic logic [BUS_W-1:0] lane_pick(input logic [BUS_W-1:0] bus,
                                                 input logic [1:0] off,
                                                 input logic [1:0] sz);
    logic [BUS_W-1:0] sh;
    sh = bus >> {off, 3'b000};
    case (sz)
      2'd0:    return BUS_W'(sh[7:0]);
      2'd1:    return BUS_W'(sh[15:0]);
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/mgr_addr_seq.sv
module mgr_addr_seq
  import ahb_mgr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic                start_wrap,
  input  logic [1:0]          size,
  input  logic                hready,
  input  logic                pause,
  input  logic                cancel,
  output logic [ADDR_W-1:0]   haddr,
  output logic [1:0]          htrans,
  output logic                issue,
  output logic [BEAT_IW-1:0]  issue_beat,
  output logic                issue_last
);

  logic [ADDR_W-1:0]  addr_q;
  trans_e             trans_q;
  logic [BEAT_IW-1:0] beat_q;
  logic               wrap_q;
  logic               real_beat;
  logic [ADDR_W-1:0]  next_addr;

  assign real_beat  = (trans_q == TR_NONSEQ) || (trans_q == TR_SEQ);
  assign issue      = hready && real_beat;
  assign issue_beat = beat_q;
  assign issue_last = !wrap_q || (beat_q == BEAT_IW'(WRAP_BEATS - 1));
  assign next_addr  = {addr_q[ADDR_W-1:LO_W], wrap_step(addr_q[LO_W-1:0], size)};
  assign haddr      = addr_q;
  assign htrans     = trans_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      trans_q <= TR_IDLE;
      beat_q  <= '0;
      wrap_q  <= 1'b0;
    end else if (start) begin
      addr_q  <= start_addr;
      trans_q <= TR_NONSEQ;
      beat_q  <= '0;
      wrap_q  <= start_wrap;
    end else if (cancel) begin
      trans_q <= TR_IDLE;
    end else if (hready) begin
      case (trans_q)
        TR_NONSEQ, TR_SEQ: begin
          if (issue_last) begin
            trans_q <= TR_IDLE;
          end else begin
            addr_q  <= next_addr;
            beat_q  <= beat_q + 1'b1;
            trans_q <= pause ? TR_BUSY : TR_SEQ;
          end
        end
        TR_BUSY: trans_q <= pause ? TR_BUSY : TR_SEQ;
        default: trans_q <= TR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mgr_data_seq.sv
module mgr_data_seq
  import ahb_mgr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue,
  input  logic [BEAT_IW-1:0]          issue_beat,
  input  logic                        issue_last,
  input  logic [1:0]                  issue_lo,
  input  logic                        write,
  input  logic [1:0]                  size,
  input  logic [WRAP_BEATS*BUS_W-1:0] wdata_all,
  input  logic                        hready,
  input  logic                        hresp,
  input  logic [BUS_W-1:0]            hrdata,
  output logic [BUS_W-1:0]            hwdata,
  output logic                        rd_valid,
  output logic [BUS_W-1:0]            rd_data,
  output logic [BEAT_IW-1:0]          rd_beat,
  output logic                        done,
  output logic                        done_err,
  output logic                        d_active,
  output logic                        err_first,
  output logic                        finish
);

  logic               act_q;
  logic [BEAT_IW-1:0] beat_q;
  logic               last_q;
  logic [1:0]         lo_q;
  logic               complete;
  logic [BUS_W-1:0]   beat_word;

  assign complete  = act_q && hready;
  assign finish    = complete && (last_q || hresp);
  assign err_first = act_q && hresp && !hready;
  assign d_active  = act_q;
  assign beat_word = wdata_all[int'(beat_q)*BUS_W +: BUS_W];
  assign hwdata    = (act_q && write) ? lane_spread(beat_word, size) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      last_q <= 1'b0;
      lo_q   <= '0;
    end else if (issue) begin
      act_q  <= 1'b1;
      beat_q <= issue_beat;
      last_q <= issue_last;
      lo_q   <= issue_lo;
    end else if (complete) begin
      act_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_beat  <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      rd_valid <= complete && !write && !hresp;
      if (complete && !write && !hresp) begin
        rd_data <= lane_pick(hrdata, lo_q, size);
        rd_beat <= beat_q;
      end
      done     <= finish;
      done_err <= finish && hresp;
    end
  end

endmodule

// File: rtl/ahb_burst_mgr.sv
module ahb_burst_mgr
  import ahb_mgr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic                        cmd_write,
  input  logic [1:0]                  cmd_size,
  input  logic                        cmd_wrap,
  input  logic [WRAP_BEATS*BUS_W-1:0] cmd_wdata,
  input  logic                        usr_pause,
  output logic                        rd_valid,
  output logic [BUS_W-1:0]            rd_data,
  output logic [BEAT_IW-1:0]          rd_beat,
  output logic                        done,
  output logic                        done_err,
  output logic [ADDR_W-1:0]           haddr,
  output logic [1:0]                  htrans,
  output logic                        hwrite,
  output logic [2:0]                  hsize,
  output logic [2:0]                  hburst,
  output logic [BUS_W-1:0]            hwdata,
  input  logic [BUS_W-1:0]            hrdata,
  input  logic                        hready,
  input  logic                        hresp
);

  logic                        busy_q;
  logic                        write_q;
  logic [1:0]                  size_q;
  logic                        wrap_q;
  logic [WRAP_BEATS*BUS_W-1:0] wdata_q;

  logic                        accept;
  logic                        beat_issue;
  logic [BEAT_IW-1:0]          beat_idx;
  logic                        beat_last;
  logic                        dphase_act;
  logic                        err_first;
  logic                        fin_evt;

  assign accept    = cmd_valid && !busy_q;
  assign cmd_ready = !busy_q;
  assign hwrite    = write_q;
  assign hsize     = {1'b0, size_q};
  assign hburst    = wrap_q ? HB_WRAP4 : HB_SINGLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      size_q  <= '0;
      wrap_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      write_q <= cmd_write;
      size_q  <= (cmd_size == 2'd3) ? 2'd2 : cmd_size;
      wrap_q  <= cmd_wrap;
      wdata_q <= cmd_wdata;
    end else if (fin_evt) begin
      busy_q  <= 1'b0;
    end
  end

  mgr_addr_seq #(.ADDR_W(ADDR_W)) addr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (cmd_addr),
    .start_wrap (cmd_wrap),
    .size       (size_q),
    .hready     (hready),
    .pause      (usr_pause),
    .cancel     (err_first),
    .haddr      (haddr),
    .htrans     (htrans),
    .issue      (beat_issue),
    .issue_beat (beat_idx),
    .issue_last (beat_last)
  );

  mgr_data_seq data_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (beat_issue),
    .issue_beat (beat_idx),
    .issue_last (beat_last),
    .issue_lo   (haddr[1:0]),
    .write      (write_q),
    .size       (size_q),
    .wdata_all  (wdata_q),
    .hready     (hready),
    .hresp      (hresp),
    .hrdata     (hrdata),
    .hwdata     (hwdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_beat    (rd_beat),
    .done       (done),
    .done_err   (done_err),
    .d_active   (dphase_act),
    .err_first  (err_first),
    .finish     (fin_evt)
  );

endmodule

// File: rtl/ahb_burst_mgr_chk.sv
module ahb_burst_mgr_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hburst,
  input logic [31:0]       hwdata,
  input logic              hready,
  input logic              hresp,
  input logic              done,
  input logic              done_err,
  input logic              rd_valid,
  input logic              d_active
);

  AST_START_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (htrans == 2'b10)); // R2

  AST_ADDR_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && !hready && !(d_active && hresp)) |=> ($stable(haddr) && $stable(htrans))); // R5

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (d_active && hwrite && !hready) |=> $stable(hwdata)); // R6

  AST_BUSY_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b01 && hready) |=> ($stable(haddr) && htrans != 2'b10)); // R8

  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (d_active && hresp && !hready) |=> (htrans == 2'b00)); // R9

  AST_ERR_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> !rd_valid); // R9

  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R10

  AST_SINGLE_NO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hburst == 3'b000) |-> (htrans != 2'b11 && htrans != 2'b01)); // R11

endmodule

bind ahb_burst_mgr ahb_burst_mgr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .haddr     (haddr),
  .htrans    (htrans),
  .hwrite    (hwrite),
  .hburst    (hburst),
  .hwdata    (hwdata),
  .hready    (hready),
  .hresp     (hresp),
  .done      (done),
  .done_err  (done_err),
  .rd_valid  (rd_valid),
  .d_active  (dphase_act)
);

// File: tb/ahb_burst_mgr_tb_top.sv
module ahb_burst_mgr_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [31:0]  cmd_addr;
  logic         cmd_write;
  logic [1:0]   cmd_size;
  logic         cmd_wrap;
  logic [127:0] cmd_wdata;
  logic         usr_pause;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic [1:0]   rd_beat;
  logic         done;
  logic         done_err;
  logic [31:0]  haddr;
  logic [1:0]   htrans;
  logic         hwrite;
  logic [2:0]   hsize;
  logic [2:0]   hburst;
  logic [31:0]  hwdata;
  logic [31:0]  hrdata;
  logic         s_hready;
  logic         s_hresp;

  always #2 clk = ~clk;

  ahb_burst_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_size(cmd_size),
    .cmd_wrap(cmd_wrap), .cmd_wdata(cmd_wdata), .usr_pause(usr_pause),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat), .done(done),
    .done_err(done_err), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata),
    .hready(s_hready), .hresp(s_hresp)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- subordinate model ----------------
  logic [7:0] mem [0:63];
  logic       dp_valid;
  logic [7:0] dp_addr;
  logic       dp_write;
  logic [1:0] dp_size;
  int         wait_left;
  int         err_phase;
  int         xfer_idx;
  int         ws_cfg = 0;
  int         err_at = -1;

  always_comb begin
    if (!dp_valid)           s_hready = 1'b1;
    else if (err_phase == 0) s_hready = (wait_left == 0);
    else                     s_hready = (err_phase == 2);
    s_hresp = dp_valid && (err_phase != 0);
  end

  always_comb begin
    int a;
    a = int'({dp_addr[5:2], 2'b00});
    hrdata = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
      dp_valid  <= 1'b0;
      dp_addr   <= '0;
      dp_write  <= 1'b0;
      dp_size   <= '0;
      wait_left <= 0;
      err_phase <= 0;
      xfer_idx  <= 0;
    end else if (s_hready) begin
      if (dp_valid && dp_write && err_phase == 0) begin
        for (int b = 0; b < 4; b++) begin
          if (b >= int'(dp_addr[1:0]) && b < int'(dp_addr[1:0]) + (1 << dp_size))
            mem[int'({dp_addr[5:2], 2'b00}) + b] <= hwdata[8*b +: 8];
        end
      end
      if (htrans[1]) begin
        dp_valid  <= 1'b1;
        dp_addr   <= haddr[7:0];
        dp_write  <= hwrite;
        dp_size   <= hsize[1:0];
        wait_left <= ws_cfg;
        err_phase <= (xfer_idx == err_at) ? 1 : 0;
        xfer_idx  <= xfer_idx + 1;
      end else begin
        dp_valid  <= 1'b0;
        err_phase <= 0;
      end
    end else if (err_phase == 1) begin
      err_phase <= 2;
    end else begin
      wait_left <= wait_left - 1;
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_addr[$];
  logic [31:0] exp_wd[$];
  logic [31:0] exp_wm[$];
  logic [31:0] exp_rd[$];
  logic [1:0]  exp_rb[$];
  bit          exp_de[$];
  logic [7:0]  shadow [0:63];
  bit          expect_nonseq = 1'b0;
  logic        exp_write;
  logic [2:0]  exp_size;
  logic [2:0]  exp_burst;
  int          busy_seen = 0;
  int          ovl_seen  = 0;
  int          done_cnt  = 0;

  logic        p_stall = 1'b0;
  logic [31:0] p_haddr;
  logic [1:0]  p_htrans;
  logic        p_wstall = 1'b0;
  logic [31:0] p_hwdata;
  logic        p_err1 = 1'b0;
  logic        p_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_stall)
        chk(haddr == p_haddr && htrans == p_htrans, "R5 stall hold", haddr, p_haddr);
      if (p_wstall)
        chk(hwdata == p_hwdata, "R6 wdata hold", hwdata, p_hwdata);
      if (p_err1)
        chk(htrans == 2'b00, "R9 idle after error", 32'(htrans), 32'd0);
      if (s_hready && htrans[1]) begin
        if (dp_valid) ovl_seen++;
        if (exp_addr.size() == 0) chk(1'b0, "R3 unexpected transfer", haddr, 32'hx);
        else begin
          logic [31:0] ea;
          ea = exp_addr.pop_front();
          chk(haddr == ea, "R4 address", haddr, ea);
          if (expect_nonseq) begin
            chk(htrans == 2'b10, "R3 first NONSEQ", 32'(htrans), 32'h2);
            chk(hwrite == exp_write && hsize == exp_size && hburst == exp_burst,
                "R2 control", {25'd0, hwrite, hsize, hburst}, {25'd0, exp_write, exp_size, exp_burst});
            expect_nonseq = 1'b0;
          end else
            chk(htrans == 2'b11, "R3 SEQ", 32'(htrans), 32'h3);
        end
      end
      if (s_hready && htrans == 2'b01) begin
        busy_seen++;
        if (exp_addr.size() != 0)
          chk(haddr == exp_addr[0], "R8 BUSY address", haddr, exp_addr[0]);
      end
      if (dp_valid && dp_write && s_hready && err_phase == 0) begin
        if (exp_wd.size() == 0) chk(1'b0, "R6 unexpected write", hwdata, 32'hx);
        else begin
          logic [31:0] ed, em;
          ed = exp_wd.pop_front();
          em = exp_wm.pop_front();
          chk((hwdata & em) == (ed & em), "R6 write lanes", hwdata & em, ed & em);
        end
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(1'b0, "R7 unexpected rd_valid", rd_data, 32'hx);
        else begin
          logic [31:0] er;
          logic [1:0]  eb;
          er = exp_rd.pop_front();
          eb = exp_rb.pop_front();
          chk(rd_data == er, "R7 read data", rd_data, er);
          chk(rd_beat == eb, "R7 read beat", 32'(rd_beat), 32'(eb));
        end
      end
      if (done) begin
        chk(!p_done, "R10 done one cycle", 32'(p_done), 32'd0);
        chk(cmd_ready == 1'b1, "R10 ready with done", 32'(cmd_ready), 32'd1);
        if (exp_de.size() == 0) chk(1'b0, "R10 unexpected done", 32'(done), 32'd0);
        else begin
          bit ee;
          ee = exp_de.pop_front();
          chk(done_err == ee, "R9 done_err", 32'(done_err), 32'(ee));
        end
        done_cnt++;
      end
      p_stall  = (htrans != 2'b00) && !s_hready && !s_hresp;
      p_haddr  = haddr;
      p_htrans = htrans;
      p_wstall = dp_valid && dp_write && !s_hready;
      p_hwdata = hwdata;
      p_err1   = s_hresp && !s_hready;
      p_done   = done;
    end
  end

  int xfer_total = 0;

  task automatic run_cmd(input logic [31:0] addr, input bit wr, input int size,
                         input bit wrap, input logic [127:0] wd, input int ws,
                         input int err_beat, input int p_start, input int p_len,
                         input int exp_busy);
    int n, n_ok, n_iss, bytes, start_cnt, cyc;
    logic [31:0] blk, ak, ex, em, rv;
    bytes = 1 << size;
    n     = wrap ? 4 : 1;
    n_ok  = (err_beat < 0) ? n : err_beat;
    n_iss = (err_beat < 0) ? n : err_beat + 1;
    blk   = 32'(4 * bytes);
    for (int k = 0; k < n_iss; k++) begin
      ak = wrap ? ((addr & ~(blk - 32'd1)) | ((addr + 32'(k * bytes)) & (blk - 32'd1))) : addr;
      exp_addr.push_back(ak);
      if (k < n_ok) begin
        if (wr) begin
          ex = wd[32*k +: 32] << (8 * ak[1:0]);
          em = 32'((64'd1 << (8 * bytes)) - 64'd1) << (8 * ak[1:0]);
          exp_wd.push_back(ex);
          exp_wm.push_back(em);
          for (int b = 0; b < bytes; b++) shadow[int'(ak[5:0]) + b] = wd[32*k + 8*b +: 8];
        end else begin
          rv = '0;
          for (int b = 0; b < bytes; b++) rv[8*b +: 8] = shadow[int'(ak[5:0]) + b];
          exp_rd.push_back(rv);
          exp_rb.push_back(2'(k));
        end
      end
    end
    exp_de.push_back(err_beat >= 0);
    err_at        = (err_beat >= 0) ? xfer_total + err_beat : -1;
    xfer_total    = xfer_total + n_iss;
    ws_cfg        = ws;
    exp_write     = wr;
    exp_size      = 3'(size);
    exp_burst     = wrap ? 3'b010 : 3'b000;
    expect_nonseq = 1'b1;
    busy_seen     = 0;
    start_cnt     = done_cnt;
    @(negedge clk);
    cmd_addr  = addr;
    cmd_write = wr;
    cmd_size  = 2'(size);
    cmd_wrap  = wrap;
    cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    usr_pause = (cyc >= p_start && cyc < p_start + p_len);
    while (done_cnt == start_cnt) begin
      @(negedge clk);
      cyc++;
      usr_pause = (cyc >= p_start && cyc < p_start + p_len);
    end
    usr_pause = 1'b0;
    chk(exp_addr.size() == 0, "R3 all beats issued", 32'(exp_addr.size()), 32'd0);
    chk(exp_rd.size() == 0 && exp_wd.size() == 0, "R7 all data beats seen",
        32'(exp_rd.size() + exp_wd.size()), 32'd0);
    if (exp_busy >= 0)
      chk(busy_seen == exp_busy, "R8 BUSY count", 32'(busy_seen), 32'(exp_busy));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'(i * 7 + 3);
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_write = 1'b0; cmd_size = '0;
    cmd_wrap = 1'b0; cmd_wdata = '0; usr_pause = 1'b0;
    repeat (3) @(negedge clk);
    chk(htrans == 2'b00 && cmd_ready && !done && !rd_valid, "R1 in reset",
        {28'd0, htrans, cmd_ready, done}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b00 && cmd_ready && !done && !rd_valid, "R1 after reset",
        {28'd0, htrans, cmd_ready, done}, 32'h2);
    // R11 single word write, then read back
    run_cmd(32'h10, 1'b1, 2, 1'b0, 128'hA5A5_1234, 0, -1, 0, 0, 0);
    run_cmd(32'h10, 1'b0, 2, 1'b0, '0, 1, -1, 0, 0, 0);
    // R4 R5 R6 wrapping word write with waits, read back
    run_cmd(32'h28, 1'b1, 2, 1'b1, {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001},
            1, -1, 0, 0, 0);
    run_cmd(32'h24, 1'b0, 2, 1'b1, '0, 2, -1, 0, 0, 0);
    chk(ovl_seen > 0, "R5 address overlaps data phase", 32'(ovl_seen), 32'd1);
    // R4 R7 halfword wrap read
    run_cmd(32'h06, 1'b0, 1, 1'b1, '0, 0, -1, 0, 0, 0);
    // R4 R6 byte wrap write at 0x33, then byte wrap read
    run_cmd(32'h33, 1'b1, 0, 1'b1, {32'h44, 32'h33, 32'h22, 32'h11}, 0, -1, 0, 0, 0);
    run_cmd(32'h31, 1'b0, 0, 1'b1, '0, 1, -1, 0, 0, 0);
    // R8 pause without waits, then with waits on a write
    run_cmd(32'h1C, 1'b0, 2, 1'b1, '0, 0, -1, 1, 2, 2);
    run_cmd(32'h3A, 1'b1, 1, 1'b1, {32'hDD04, 32'hCC03, 32'hBB02, 32'hAA01}, 1, -1, 2, 3, -1);
    run_cmd(32'h38, 1'b0, 1, 1'b1, '0, 0, -1, 3, 1, -1);
    // R9 error on beat 1 of a read, on beat 0 of a write
    run_cmd(32'h08, 1'b0, 2, 1'b1, '0, 1, 1, 0, 0, 0);
    run_cmd(32'h20, 1'b1, 2, 1'b1, {4{32'hDEAD_BEEF}}, 0, 0, 0, 0, 0);
    // R10 engine usable after error
    run_cmd(32'h20, 1'b0, 2, 1'b0, '0, 0, -1, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule